// File: doc/BRIEF.md
# Interrupt Controller Command-3 Path

This block is the third operational command path of an eight-level interrupt controller, together with the request, in-service and mask state that the command acts on. A byte written to the command port is taken as this command when its bits 4:3 hold 01 and bit 7 is 0. The command chooses which status register a command-port read returns, and that choice stays in place until it is changed. The command can also arm a single poll. It can switch special mask mode on or off, which changes how in-service levels hold back lower-priority requests.

A poll turns the next command-port read into an acknowledge. That read returns an encoded byte naming the highest level that may be serviced, and it moves that level from pending to in service. Priority is fixed, with level 0 highest. A single init pulse stands in for the full initialization sequence.

Top module: `pic_ocw3_ctrl`

## Requirements
- R1: After reset or an init pulse, a command-port read returns the request register (IRR), special mask mode is off, and the in-service (ISR) and mask (IMR) registers are zero. An init pulse leaves the IRR as it is.
- R2: A command write is decoded as this command only when wr_data[4:3] = 01 and wr_data[7] = 0. Any other command byte leaves the read selection, the poll state and the mask mode unchanged.
- R3: Command bits 1:0 = 10 select the IRR and 11 select the ISR. The selection holds across any number of reads.
- R4: Command bits 1:0 = 00 or 01 leave the read selection unchanged.
- R5: Command bit 2 arms a poll. The next read returns 8'h80 | level when a level is granted and 8'h00 otherwise. The poll clears after that one read, and later reads follow the held selection again.
- R6: A poll read that grants a level sets that level's ISR bit and clears its IRR bit.
- R7: Command bit 6 sets (1) or clears (0) special mask mode only when bit 5 is 1. When bit 5 is 0, the mode stays as it was.
- R8: Outside special mask mode, a level in service blocks requests at its own level and at all lower-priority levels.
- R9: In special mask mode, an in-service level that is also masked in the IMR does not block. Lower unmasked levels can then be granted.
- R10: int_out is high exactly when an unmasked IRR level outranks every in-service level that blocks. Level 0 is the highest priority.
- R11: A data-port write loads the IMR. A masked IRR bit is never granted and never raises int_out.
- R12: A high bit on req_in sets the matching IRR bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_pulse | input | 1 | Marks the end of initialization; one cycle wide |
| req_in | input | 8 | Request lines, one per level |
| cmd_wr | input | 1 | Command-port write strobe |
| data_wr | input | 1 | Data-port write strobe (loads the IMR) |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Command-port read strobe |
| rd_data | output | 8 | Read data: the IRR, the ISR or the poll byte |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions check on every cycle that the read selection and the mask mode change only on a qualifying command or an init pulse. They also check that a poll disarms after one read, that a granted poll sets its ISR bit, and that int_out never rises without an unmasked pending request. The bench scenarios show the behaviour that depends on whole sequences. These are the default IRR read after init, the selection held across repeated reads and across 00/01 commands, and a poll read followed by an ordinary read. They also cover equal- and lower-priority blocking, and how the grant changes as mask mode is toggled with and without its enable bit.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_LVL = 8;
  localparam int unsigned LVL_W = $clog2(NUM_LVL);

  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_SVC = 1'b1
  } rdsel_e;

  typedef struct packed {
    logic       resv;
    logic       smm_val;
    logic       smm_en;
    logic [1:0] kind;
    logic       poll;
    logic       sel_upd;
    logic       sel_svc;
  } cmd3_t;

  localparam logic [1:0] KIND_CMD3 = 2'b01;
endpackage

// File: rtl/pic_ocw3_decode.sv
module pic_ocw3_decode
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_pulse,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output rdsel_e            sel,
  output logic              poll_armed,
  output logic              smm
);
  cmd3_t  cmd;
  logic   is_cmd3;
  rdsel_e sel_d;
  logic   poll_d;
  logic   smm_d;

  assign cmd     = cmd3_t'(wr_data);
  assign is_cmd3 = cmd_wr && (cmd.kind == KIND_CMD3) && !cmd.resv;

  always_comb begin
    sel_d  = sel;
    poll_d = poll_armed;
    smm_d  = smm;
    if (rd_en) poll_d = 1'b0;
    if (is_cmd3) begin
      if (cmd.sel_upd) sel_d = cmd.sel_svc ? SEL_SVC : SEL_REQ;
      if (cmd.poll)    poll_d = 1'b1;
      if (cmd.smm_en)  smm_d = cmd.smm_val;
    end
    if (init_pulse) begin
      sel_d  = SEL_REQ;
      poll_d = 1'b0;
      smm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel        <= SEL_REQ;
      poll_armed <= 1'b0;
      smm        <= 1'b0;
    end else begin
      sel        <= sel_d;
      poll_armed <= poll_d;
      smm        <= smm_d;
    end
  end

  // R3 / R4: selection moves only on a command with bit 1 set, or on init
  p_sel_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && wr_data[1]) && !init_pulse |=> $stable(sel));

  // R7: mask mode moves only with its enable bit, or on init
  p_smm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && wr_data[5]) && !init_pulse |=> $stable(smm));

  // R5: poll is one-shot
  p_poll_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && poll_armed && !cmd_wr |=> !poll_armed);

  // R2: reserved bit set means no effect
  p_resv_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wr_data[7] && !init_pulse && !rd_en |=>
      $stable(sel) && $stable(smm) && $stable(poll_armed));
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int unsigned LEVELS = 8,
  localparam int unsigned LW = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] irr,
  input  logic [LEVELS-1:0] isr,
  input  logic [LEVELS-1:0] imr,
  input  logic              smm,
  output logic              grant_valid,
  output logic [LW-1:0]     grant_lvl
);
  logic [LEVELS-1:0] cand;
  logic [LEVELS-1:0] blk;
  logic              cand_any;
  logic              blk_any;
  logic [LW-1:0]     cand_lvl;
  logic [LW-1:0]     blk_lvl;

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    assign cand[i] = irr[i] & ~imr[i];
    assign blk[i]  = isr[i] & ~(smm & imr[i]);
  end

  always_comb begin
    cand_any = 1'b0;
    cand_lvl = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        cand_any = 1'b1;
        cand_lvl = LW'(i);
      end
    end
  end

  always_comb begin
    blk_any = 1'b0;
    blk_lvl = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (blk[i]) begin
        blk_any = 1'b1;
        blk_lvl = LW'(i);
      end
    end
  end

  assign grant_valid = cand_any && (!blk_any || (cand_lvl < blk_lvl));
  assign grant_lvl   = cand_lvl;

  // R11: a granted level is never masked; R10: grant needs a pending request
  always_comb begin
    p_grant_unmasked_r11: assert (!grant_valid || (irr[grant_lvl] && !imr[grant_lvl]));
  end
endmodule

// File: rtl/pic_irq_regs.sv
module pic_irq_regs #(
  parameter int unsigned LEVELS = 8,
  localparam int unsigned LW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_pulse,
  input  logic [LEVELS-1:0] req_in,
  input  logic              imr_wr,
  input  logic [LEVELS-1:0] imr_val,
  input  logic              ack,
  input  logic [LW-1:0]     ack_lvl,
  output logic [LEVELS-1:0] irr,
  output logic [LEVELS-1:0] isr,
  output logic [LEVELS-1:0] imr
);
  logic [LEVELS-1:0] ack_mask;
  logic [LEVELS-1:0] irr_d;
  logic [LEVELS-1:0] isr_d;
  logic [LEVELS-1:0] imr_d;

  assign ack_mask = ack ? (LEVELS'(1) << ack_lvl) : '0;

  always_comb begin
    irr_d = (irr | req_in) & ~ack_mask;
    isr_d = isr | ack_mask;
    imr_d = imr_wr ? imr_val : imr;
    if (init_pulse) begin
      isr_d = '0;
      imr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      imr <= '0;
    end else begin
      irr <= irr_d;
      isr <= isr_d;
      imr <= imr_d;
    end
  end

  // R6: an acknowledged level enters service
  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !init_pulse |=> isr[$past(ack_lvl)]);

  // R12: a raised request line lands in the IRR unless acknowledged
  p_req_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((irr & $past(req_in)) == $past(req_in)));
endmodule

// File: rtl/pic_ocw3_ctrl.sv
module pic_ocw3_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_pulse,
  input  logic [NUM_LVL-1:0] req_in,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              int_out
);
  rdsel_e             sel;
  logic               poll_armed;
  logic               smm;
  logic [NUM_LVL-1:0] irr;
  logic [NUM_LVL-1:0] isr;
  logic [NUM_LVL-1:0] imr;
  logic               grant_valid;
  logic [LVL_W-1:0]   grant_lvl;
  logic               poll_rd;
  logic [BYTE_W-1:0]  poll_byte;

  pic_ocw3_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_pulse (init_pulse),
    .cmd_wr     (cmd_wr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .sel        (sel),
    .poll_armed (poll_armed),
    .smm        (smm)
  );

  assign poll_rd = rd_en && poll_armed;

  pic_irq_regs #(.LEVELS(NUM_LVL)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_pulse (init_pulse),
    .req_in     (req_in),
    .imr_wr     (data_wr),
    .imr_val    (wr_data[NUM_LVL-1:0]),
    .ack        (poll_rd && grant_valid),
    .ack_lvl    (grant_lvl),
    .irr        (irr),
    .isr        (isr),
    .imr        (imr)
  );

  pic_prio_resolve #(.LEVELS(NUM_LVL)) u_res (
    .irr         (irr),
    .isr         (isr),
    .imr         (imr),
    .smm         (smm),
    .grant_valid (grant_valid),
    .grant_lvl   (grant_lvl)
  );

  always_comb begin
    poll_byte = '0;
    if (grant_valid) begin
      poll_byte[BYTE_W-1]  = 1'b1;
      poll_byte[LVL_W-1:0] = grant_lvl;
    end
  end

  always_comb begin
    if (poll_armed)          rd_data = poll_byte;
    else if (sel == SEL_SVC) rd_data = isr;
    else                     rd_data = irr;
  end

  assign int_out = grant_valid;

  // R10: no interrupt without an unmasked pending request
  p_int_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));

  // R5: poll byte carries no bits between the flag and the level
  p_poll_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_armed |-> (rd_data[BYTE_W-2:LVL_W] == '0));
endmodule

// File: tb/tb_pic_ocw3_ctrl.sv
module tb_pic_ocw3_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_pulse = 1'b0;
  logic [7:0] req_in = '0;
  logic       cmd_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       int_out;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pic_ocw3_ctrl dut (
    .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse), .req_in(req_in),
    .cmd_wr(cmd_wr), .data_wr(data_wr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .int_out(int_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1'b1; wr_data = b;
    @(negedge clk); cmd_wr = 1'b0; wr_data = '0;
  endtask

  task automatic set_mask(input logic [7:0] b);
    @(negedge clk); data_wr = 1'b1; wr_data = b;
    @(negedge clk); data_wr = 1'b0; wr_data = '0;
  endtask

  task automatic raise(input logic [7:0] r);
    @(negedge clk); req_in = r;
    @(negedge clk); req_in = '0;
  endtask

  task automatic do_init();
    @(negedge clk); init_pulse = 1'b1;
    @(negedge clk); init_pulse = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1;
    #1 chk(tag, rd_data, exp);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic int_chk(input string tag, input logic exp);
    @(negedge clk); #1 chk(tag, {7'd0, int_out}, {7'd0, exp});
  endtask

  task automatic t_reset();
    rd_chk("R1 reset read", 8'h00);
    int_chk("R1 reset int", 1'b0);
    raise(8'h08);
    rd_chk("R12 request latched", 8'h08);
    do_init();
    rd_chk("R1 default IRR after init", 8'h08);
    int_chk("R10 pending level 3", 1'b1);
  endtask

  task automatic t_select();
    cmd(8'h0B);
    rd_chk("R3 ISR select", 8'h00);
    rd_chk("R3 ISR repeat", 8'h00);
    cmd(8'h08);
    rd_chk("R4 code 00 keeps ISR", 8'h00);
    cmd(8'h09);
    rd_chk("R4 code 01 keeps ISR", 8'h00);
    cmd(8'h0A);
    rd_chk("R3 IRR select", 8'h08);
    rd_chk("R3 IRR repeat", 8'h08);
  endtask

  task automatic t_reserved();
    cmd(8'h8B);
    rd_chk("R2 bit7 set ignored", 8'h08);
    cmd(8'h13);
    rd_chk("R2 wrong kind ignored", 8'h08);
  endtask

  task automatic t_poll();
    cmd(8'h0C);
    rd_chk("R5 poll byte level 3", 8'h83);
    rd_chk("R5 one-shot then IRR, R6 IRR cleared", 8'h00);
    cmd(8'h0B);
    rd_chk("R6 ISR bit set", 8'h08);
    cmd(8'h0C);
    rd_chk("R5 empty poll", 8'h00);
    cmd(8'h0A);
  endtask

  task automatic t_block();
    raise(8'h20);
    int_chk("R8 lower level blocked", 1'b0);
    raise(8'h08);
    int_chk("R8 equal level blocked", 1'b0);
    raise(8'h02);
    int_chk("R10 higher level granted", 1'b1);
    cmd(8'h0C);
    rd_chk("R5 poll level 1", 8'h81);
  endtask

  task automatic t_smm();
    do_init();
    rd_chk("R1 IRR kept over init", 8'h28);
    cmd(8'h0C);
    rd_chk("R5 poll level 3 after init", 8'h83);
    int_chk("R8 level 5 blocked", 1'b0);
    set_mask(8'h08);
    int_chk("R9 normal mode masked ISR still blocks", 1'b0);
    cmd(8'h48);
    int_chk("R7 bit6 without enable ignored", 1'b0);
    cmd(8'h68);
    int_chk("R9 special mode unblocks", 1'b1);
    cmd(8'h0C);
    rd_chk("R9 poll level 5 in special mode", 8'h85);
    raise(8'h10);
    int_chk("R9 level 4 outranks blocking 5", 1'b1);
    cmd(8'h28);
    int_chk("R7 mode cleared", 1'b0);
    cmd(8'h68);
    int_chk("R7 mode set again", 1'b1);
    set_mask(8'h18);
    int_chk("R11 masked request no int", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_reserved();
    t_poll();
    t_block();
    t_smm();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule